// File: doc/BRIEF.md
# Time-Multiplexed Panel Switch Scanner

This block reads a front panel on a fixed service period. A free-running counter marks one service tick every `TICK_CYC` clock cycles. Each tick opens a window with two phases. In the first phase all scan lines stay high and the active-low status gate is asserted, so the fast status inputs (tempo clock, start/stop, tap) are captured on every tick. In the second phase one scan line is driven low. That line selects one group of step switches plus that group's function switches, and their return levels are captured. After the window the panel lines rest until the next tick.

The low scan line rotates by one on each tick. A group of matrix switches is therefore refreshed once every `NUM_ROWS` ticks, while the status inputs are refreshed on every tick. A step switch seen closed during the switch phase lights its step LED on the next cycle. The LED stays lit until the next tick clears the drive register. Every phase length is a parameter in clock cycles. Switch returns are active high, meaning closed.

Top module: `panel_scanner`

## Requirements
- R1: After reset release, the first service tick starts on the first clock edge. Ticks then repeat every `TICK_CYC` cycles. In each tick, `stat_gate_n_o` is low for exactly the first `STAT_CYC` cycles and high for the rest.
- R2: While the status gate is low, every bit of `scan_n_o` is high.
- R3: `status_i` is registered on the last cycle of the status phase. `status_vld_o` pulses high for one cycle, on the cycle after that sample, with `status_o` holding the sampled value.
- R4: During the switch phase, `STAT_CYC` to `STAT_CYC+SW_CYC-1` cycles into a tick, exactly one bit of `scan_n_o` is low. That bit is the current row index, with bit r corresponding to row r. The status gate is high.
- R5: The row is 0 in the first tick after reset. It advances by one per tick and wraps from `NUM_ROWS-1` to 0.
- R6: On the last switch-phase cycle, `step_ret_i` is stored into `step_o[row*STEPS +: STEPS]` and `func_ret_i` into `func_o[row*FUNC_W +: FUNC_W]`. The slices of all other rows keep their values. `row_vld_o` pulses for one cycle after the sample, with `row_id_o` equal to the row.
- R7: A step return that is high during any switch-phase cycle sets `led_o[row*STEPS+i]` from the next cycle on. The bit holds until the first cycle of the next tick, when all of `led_o` is zero. Step returns during the status phase set no LED.
- R8: Outside the window, all of `scan_n_o` and `stat_gate_n_o` are high.
- R9: In reset, all scan lines and the gate are high, and the strobes, `status_o`, `step_o`, `func_o` and `led_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | STAT_W | Fast status inputs read through the gate |
| step_ret_i | input | STEPS | Step switch returns of the selected row, high = closed |
| func_ret_i | input | FUNC_W | Function switch returns of the selected row, high = closed |
| scan_n_o | output | NUM_ROWS | Scan lines, active low |
| stat_gate_n_o | output | 1 | Status gate enable, active low |
| status_o | output | STAT_W | Last captured status |
| status_vld_o | output | 1 | One-cycle strobe for a new status capture |
| step_o | output | NUM_ROWS*STEPS | Captured step switch states, one slice per row |
| func_o | output | NUM_ROWS*FUNC_W | Captured function switch states, one slice per row |
| row_vld_o | output | 1 | One-cycle strobe for a new row capture |
| row_id_o | output | $clog2(NUM_ROWS) | Row of the latest row capture |
| led_o | output | NUM_ROWS*STEPS | Step LED drive |

## Verification
The hardest case is a row capture that must leave the other three rows' slices untouched. A row's slice changes only once every four ticks, so a stale or misplaced write shows up only after the rotation has wrapped. The bench therefore drives ten ticks with a different switch pattern on each one, which takes the rotation through more than two full turns, and compares the whole `step_o` and `func_o` buses against a shadow copy after every row strobe. The bench also drives step returns through the status phase to show that no LED lights before the switch phase begins.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;
   typedef enum logic [1:0] {
      PH_STATUS = 2'd0,
      PH_SWITCH = 2'd1,
      PH_IDLE   = 2'd2
   } scan_phase_e;
endpackage

// File: rtl/scan_timer.sv
module scan_timer
   import panel_scan_pkg::*;
#(
   parameter int TICK_CYC = 1900,
   parameter int STAT_CYC = 150,
   parameter int SW_CYC   = 450
) (
   input  logic        clk,
   input  logic        rst_n,
   output scan_phase_e phase,
   output logic        stat_last,
   output logic        sw_last,
   output logic        tick_last
);
   localparam int CW    = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
   localparam int WEND  = STAT_CYC + SW_CYC;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CW'(TICK_CYC - 1);
      end else if (cnt_q == CW'(TICK_CYC - 1)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      if (cnt_q < CW'(STAT_CYC)) begin
         phase = PH_STATUS;
      end else if (cnt_q < CW'(WEND)) begin
         phase = PH_SWITCH;
      end else begin
         phase = PH_IDLE;
      end
   end

   assign stat_last = (cnt_q == CW'(STAT_CYC - 1));
   assign sw_last   = (cnt_q == CW'(WEND - 1));
   assign tick_last = (cnt_q == CW'(TICK_CYC - 1));

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(TICK_CYC));

   // R1
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_last |=> (cnt_q == '0));
endmodule

// File: rtl/scan_row_sel.sv
module scan_row_sel
   import panel_scan_pkg::*;
#(
   parameter int NUM_ROWS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick_last,
   input  scan_phase_e                 phase,
   output logic [$clog2(NUM_ROWS)-1:0] row,
   output logic [NUM_ROWS-1:0]         scan_n
);
   localparam int RW = $clog2(NUM_ROWS);
   localparam bit POW2 = (NUM_ROWS == (1 << RW));

   logic [RW-1:0] row_q;

   generate
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= RW'(NUM_ROWS - 1);
            end else if (tick_last) begin
               row_q <= row_q + 1'b1;
            end
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= RW'(NUM_ROWS - 1);
            end else if (tick_last) begin
               row_q <= (row_q == RW'(NUM_ROWS - 1)) ? '0 : row_q + 1'b1;
            end
         end
      end
   endgenerate

   for (genvar g = 0; g < NUM_ROWS; g++) begin : g_line
      assign scan_n[g] = !((phase == PH_SWITCH) && (row_q == RW'(g)));
   end

   assign row = row_q;

   // R5
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_last |=> $stable(row_q));

   // R5
   row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= RW'(NUM_ROWS - 1));
endmodule

// File: rtl/scan_capture.sv
module scan_capture
   import panel_scan_pkg::*;
#(
   parameter int NUM_ROWS = 4,
   parameter int STEPS    = 4,
   parameter int FUNC_W   = 2,
   parameter int STAT_W   = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  scan_phase_e                  phase,
   input  logic                         stat_last,
   input  logic                         sw_last,
   input  logic                         tick_last,
   input  logic [$clog2(NUM_ROWS)-1:0]  row,
   input  logic [STAT_W-1:0]            status_i,
   input  logic [STEPS-1:0]             step_i,
   input  logic [FUNC_W-1:0]            func_i,
   output logic [STAT_W-1:0]            status_q,
   output logic                         status_vld,
   output logic [NUM_ROWS*STEPS-1:0]    step_q,
   output logic [NUM_ROWS*FUNC_W-1:0]   func_q,
   output logic                         row_vld,
   output logic [$clog2(NUM_ROWS)-1:0]  row_id,
   output logic [NUM_ROWS*STEPS-1:0]    led_q
);
   localparam int RW = $clog2(NUM_ROWS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q   <= '0;
         status_vld <= 1'b0;
      end else begin
         status_vld <= stat_last;
         if (stat_last) begin
            status_q <= status_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= '0;
         func_q  <= '0;
         row_vld <= 1'b0;
         row_id  <= '0;
      end else begin
         row_vld <= sw_last;
         if (sw_last) begin
            row_id <= row;
            for (int r = 0; r < NUM_ROWS; r++) begin
               if (row == RW'(r)) begin
                  step_q[r*STEPS +: STEPS]   <= step_i;
                  func_q[r*FUNC_W +: FUNC_W] <= func_i;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q <= '0;
      end else if (tick_last) begin
         led_q <= '0;
      end else if (phase == PH_SWITCH) begin
         for (int r = 0; r < NUM_ROWS; r++) begin
            if (row == RW'(r)) begin
               led_q[r*STEPS +: STEPS] <= led_q[r*STEPS +: STEPS] | step_i;
            end
         end
      end
   end

   // R3
   status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_vld |=> !status_vld);

   // R6
   row_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_vld |=> !row_vld);

   // R7
   led_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_last |=> (led_q == '0));

   // R7
   led_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STATUS) |=> $stable(led_q));
endmodule

// File: rtl/panel_scanner.sv
module panel_scanner
   import panel_scan_pkg::*;
#(
   parameter int TICK_CYC = 1900,
   parameter int STAT_CYC = 150,
   parameter int SW_CYC   = 450,
   parameter int NUM_ROWS = 4,
   parameter int STEPS    = 4,
   parameter int FUNC_W   = 2,
   parameter int STAT_W   = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [STAT_W-1:0]            status_i,
   input  logic [STEPS-1:0]             step_ret_i,
   input  logic [FUNC_W-1:0]            func_ret_i,
   output logic [NUM_ROWS-1:0]          scan_n_o,
   output logic                         stat_gate_n_o,
   output logic [STAT_W-1:0]            status_o,
   output logic                         status_vld_o,
   output logic [NUM_ROWS*STEPS-1:0]    step_o,
   output logic [NUM_ROWS*FUNC_W-1:0]   func_o,
   output logic                         row_vld_o,
   output logic [$clog2(NUM_ROWS)-1:0]  row_id_o,
   output logic [NUM_ROWS*STEPS-1:0]    led_o
);
   localparam int RW = $clog2(NUM_ROWS);

   initial begin
      assert (STAT_CYC >= 1) else $error("STAT_CYC must be at least 1");
      assert (SW_CYC >= 1) else $error("SW_CYC must be at least 1");
      assert (TICK_CYC > STAT_CYC + SW_CYC)
         else $error("TICK_CYC must exceed the service window");
      assert (NUM_ROWS >= 2) else $error("NUM_ROWS must be at least 2");
      assert (STEPS >= 1 && FUNC_W >= 1 && STAT_W >= 1)
         else $error("field widths must be positive");
   end

   scan_phase_e   phase;
   logic          stat_last;
   logic          sw_last;
   logic          tick_last;
   logic [RW-1:0] row;

   scan_timer #(
      .TICK_CYC (TICK_CYC),
      .STAT_CYC (STAT_CYC),
      .SW_CYC   (SW_CYC)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .stat_last (stat_last),
      .sw_last   (sw_last),
      .tick_last (tick_last)
   );

   scan_row_sel #(
      .NUM_ROWS (NUM_ROWS)
   ) i_row_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_last (tick_last),
      .phase     (phase),
      .row       (row),
      .scan_n    (scan_n_o)
   );

   scan_capture #(
      .NUM_ROWS (NUM_ROWS),
      .STEPS    (STEPS),
      .FUNC_W   (FUNC_W),
      .STAT_W   (STAT_W)
   ) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .stat_last  (stat_last),
      .sw_last    (sw_last),
      .tick_last  (tick_last),
      .row        (row),
      .status_i   (status_i),
      .step_i     (step_ret_i),
      .func_i     (func_ret_i),
      .status_q   (status_o),
      .status_vld (status_vld_o),
      .step_q     (step_o),
      .func_q     (func_o),
      .row_vld    (row_vld_o),
      .row_id     (row_id_o),
      .led_q      (led_o)
   );

   assign stat_gate_n_o = (phase != PH_STATUS);

   // R2
   gate_scan_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_gate_n_o |-> (&scan_n_o));

   // R4
   single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~scan_n_o) <= 1);

   // R4
   low_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&scan_n_o) |-> stat_gate_n_o);

   // R6
   strobe_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_vld_o && row_vld_o));
endmodule

// File: tb/test_panel_scanner.sv
module test_panel_scanner;
   localparam int CLK_PERIOD = 10;
   localparam int T   = 40;
   localparam int S   = 6;
   localparam int W   = 10;
   localparam int NR  = 4;
   localparam int ST  = 4;
   localparam int FW  = 2;
   localparam int STW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [STW-1:0]    status_i = '0;
   logic [ST-1:0]     step_ret_i = '0;
   logic [FW-1:0]     func_ret_i = '0;
   logic [NR-1:0]     scan_n_o;
   logic              stat_gate_n_o;
   logic [STW-1:0]    status_o;
   logic              status_vld_o;
   logic [NR*ST-1:0]  step_o;
   logic [NR*FW-1:0]  func_o;
   logic              row_vld_o;
   logic [1:0]        row_id_o;
   logic [NR*ST-1:0]  led_o;

   panel_scanner #(
      .TICK_CYC (T), .STAT_CYC (S), .SW_CYC (W),
      .NUM_ROWS (NR), .STEPS (ST), .FUNC_W (FW), .STAT_W (STW)
   ) i_panel_scanner (
      .clk (clk), .rst_n (rst_n), .status_i (status_i),
      .step_ret_i (step_ret_i), .func_ret_i (func_ret_i),
      .scan_n_o (scan_n_o), .stat_gate_n_o (stat_gate_n_o),
      .status_o (status_o), .status_vld_o (status_vld_o),
      .step_o (step_o), .func_o (func_o), .row_vld_o (row_vld_o),
      .row_id_o (row_id_o), .led_o (led_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;
   logic [ST-1:0]    cur_step = '0;
   logic [STW-1:0]   stat_q[$];
   logic [7:0]       row_q[$];
   logic [NR*ST-1:0] sh_step = '0;
   logic [NR*FW-1:0] sh_func = '0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && cyc >= 1) begin
         int c;
         int rw;
         logic [2:0] est;
         logic [7:0] er;
         c  = (cyc - 1) % T;
         rw = ((cyc - 1) / T) % NR;
         if (c < S) begin
            chk("R1 gate low in status phase", {31'd0, stat_gate_n_o}, 32'd0);
            chk("R2 scan high in status phase", {28'd0, scan_n_o}, 32'hF);
         end else if (c < S + W) begin
            chk("R4 gate high in switch phase", {31'd0, stat_gate_n_o}, 32'd1);
            chk("R4 R5 one scan line low", {28'd0, scan_n_o}, {28'd0, ~(4'b1 << rw)});
         end else begin
            chk("R8 idle gate", {31'd0, stat_gate_n_o}, 32'd1);
            chk("R8 idle scan", {28'd0, scan_n_o}, 32'hF);
         end
         chk("R3 status strobe timing", {31'd0, status_vld_o}, {31'd0, (c == S)});
         chk("R6 row strobe timing", {31'd0, row_vld_o}, {31'd0, (c == S + W)});
         if (status_vld_o) begin
            if (stat_q.size() == 0) chk("R3 unexpected status", 32'd1, 32'd0);
            else begin
               est = stat_q.pop_front();
               chk("R3 status value", {29'd0, status_o}, {29'd0, est});
            end
         end
         if (row_vld_o) begin
            if (row_q.size() == 0) chk("R6 unexpected row", 32'd1, 32'd0);
            else begin
               er = row_q.pop_front();
               chk("R5 row id", {30'd0, row_id_o}, {30'd0, er[7:6]});
               sh_step[er[7:6]*ST +: ST] = er[3:0];
               sh_func[er[7:6]*FW +: FW] = er[5:4];
               chk("R6 step slices", {16'd0, step_o}, {16'd0, sh_step});
               chk("R6 func slices", {24'd0, func_o}, {24'd0, sh_func});
            end
         end
         if (c == S) chk("R7 no led from status phase", {16'd0, led_o}, 32'd0);
         if (c == S + 1) chk("R7 led set", {16'd0, led_o}, {16'd0, 16'(cur_step) << (rw * ST)});
         if (c == T - 1) chk("R7 led held", {16'd0, led_o}, {16'd0, 16'(cur_step) << (rw * ST)});
         if (c == 0 && cyc > 1) chk("R7 led cleared at tick", {16'd0, led_o}, 32'd0);
      end
   end

   task automatic run_tick(input logic [2:0] st, input logic [3:0] sp, input logic [1:0] fn);
      int rw;
      do @(negedge clk); while (!(cyc >= 1 && ((cyc - 1) % T) == 0));
      rw = ((cyc - 1) / T) % NR;
      status_i   = st;
      step_ret_i = sp;
      func_ret_i = fn;
      cur_step   = sp;
      stat_q.push_back(st);
      row_q.push_back({2'(rw), fn, sp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset scan", {28'd0, scan_n_o}, 32'hF);
      chk("R9 reset gate", {31'd0, stat_gate_n_o}, 32'd1);
      chk("R9 reset strobes", {30'd0, status_vld_o, row_vld_o}, 32'd0);
      chk("R9 reset data", {13'd0, status_o, step_o}, 32'd0);
      chk("R9 reset func led", {8'd0, func_o, led_o}, 32'd0);
      rst_n = 1'b1;
      run_tick(3'b101, 4'b0001, 2'b01);
      run_tick(3'b010, 4'b1010, 2'b10);
      run_tick(3'b111, 4'b1111, 2'b11);
      run_tick(3'b000, 4'b0000, 2'b00);
      run_tick(3'b001, 4'b0110, 2'b10);
      run_tick(3'b100, 4'b1000, 2'b01);
      run_tick(3'b011, 4'b0101, 2'b00);
      run_tick(3'b110, 4'b0011, 2'b11);
      run_tick(3'b010, 4'b1001, 2'b01);
      run_tick(3'b101, 4'b0100, 2'b10);
      repeat (T + 2) @(negedge clk);
      done = 1;
      chk("R6 queues drained", stat_q.size() + row_q.size(), 32'd0);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired");
      summary();
      $finish;
   end
endmodule